// File: doc/BRIEF.md
# External Interrupt Controller

This block collects up to 32 external interrupt pins into a single interrupt request for a processor. Each pin is first passed through a two-flop synchroniser. It is then judged against its own trigger setting: rising edge, falling edge, active-high level or active-low level. A trigger sets the line's status bit.

A line is pending when its status bit and its mask bit are both set. The block drives one combined request and the index of the highest-numbered pending line, so the handler can serve lines from the top down.

Software works through a simple synchronous register bus. The bus has a word address, a write strobe, write data and read data; reads are combinational on the address. The mask is changed only through separate set and clear words. Status is cleared by writing ones. Only the configured number of lines is built, and all other bits read as zero. Writing all ones to the trigger-type word and reading it back therefore shows which lines exist.

Top module: `ext_irq_ctrl`

Register words (address, name, access): 0 trig_type (rw), 1 edge_pol (rw), 2 level_pol (rw), 3 mask_set (w), 4 mask_clr (w), 5 mask (r), 6 status (r), 7 status_clr (w). Write-only words read as zero. Bit i of every word belongs to line i.

## Requirements
- R1: Writing status_clr clears each status bit whose data bit is 1. Data bits of 0 leave status unchanged.
- R2: A 1 written to mask_set sets that line's mask bit, and a 1 written to mask_clr clears it. The mask word reads back the current mask.
- R3: A trig_type bit of 1 makes that line level-triggered, and 0 makes it edge-triggered.
- R4: In edge mode, an edge_pol bit of 1 selects rising edges and 0 selects falling edges. The opposite edge has no effect on status.
- R5: In level mode, a level_pol bit of 1 selects an active-high input and 0 selects an active-low input.
- R6: Bits at or above NUM_LINES are not writable and read as 0 in every word. After all ones are written to trig_type, it reads back (1<<NUM_LINES)-1.
- R7: irq_o is high exactly when some line has both status and mask set. A status bit without its mask bit does not raise irq_o.
- R8: While irq_o is high, irq_idx_o holds the highest line number whose status and mask bits are both set.
- R9: After reset, every register reads zero, irq_o is low and irq_idx_o is zero. Every line then triggers on a falling edge.
- R10: A pin change shows in status after the third rising clock edge following it: two synchroniser flops, then the status register.
- R11: In level mode, the status bit is set again on every cycle the input is active. A clear therefore only sticks once the input is inactive.
- R12: Triggers set status even while the line is masked. A trigger in the same cycle as a clear of that bit wins, and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt request |
| irq_idx_o | output | IDX_W | Highest pending line number |

## Verification
The assertions assume a write strobe is only valid on the named word addresses, one word per cycle. They also assume the pins meet the synchroniser only as slow-changing levels, so the trigger events seen inside are single clean events per transition. The bench keeps to this by changing pins away from the clock edge and holding each level for at least three cycles. It also issues one bus write at a time, each lasting exactly one cycle. A same-cycle trigger and clear is produced on purpose by timing the write against the known three-edge latency.

// File: rtl/eic_pkg.sv
// Package: shared constants and register word addresses of the
// external interrupt controller. Assumes a 32-bit data bus.
package eic_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_TRIG_TYPE  = 4'd0,
        A_EDGE_POL   = 4'd1,
        A_LEVEL_POL  = 4'd2,
        A_MASK_SET   = 4'd3,
        A_MASK_CLR   = 4'd4,
        A_MASK       = 4'd5,
        A_STATUS     = 4'd6,
        A_STATUS_CLR = 4'd7
    } eic_addr_e;
endpackage

// File: rtl/eic_sync.sv
// Module: two-flop synchroniser per pin plus a one-cycle history flop.
// Assumes pins are asynchronous levels; resets all flops to 0.
module eic_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Synchronise pins and keep the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign now_o  = sync_q;
    assign prev_o = hist_q;
endmodule

// File: rtl/eic_trigger.sv
// Module: per-line trigger decision from synchronised samples.
// Assumes now/prev are synchronous; output is a one-cycle event vector.
module eic_trigger #(
    parameter int W = 8
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] lvl_mode_i,
    input  logic [W-1:0] edge_pol_i,
    input  logic [W-1:0] level_pol_i,
    output logic [W-1:0] evt_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic rise, fall, active;
        // Classify the sample pair of one line.
        always_comb begin
            rise   = now_i[g] & ~prev_i[g];
            fall   = ~now_i[g] & prev_i[g];
            active = (now_i[g] == level_pol_i[g]);
            if (lvl_mode_i[g]) evt_o[g] = active;
            else               evt_o[g] = edge_pol_i[g] ? rise : fall;
        end
    end
endmodule

// File: rtl/eic_prio.sv
// Module: highest-set-bit encoder over the pending vector.
// Assumes index 0 is reported when nothing is pending.
module eic_prio #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan upward so the highest set bit is the last one kept.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: external interrupt controller top. Holds the config, mask
// and status registers, serves the register bus, and drives the request.
// Assumes one bus write per cycle and NUM_LINES between 1 and 32.
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter  int NUM_LINES = 8,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_pin_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o,
    output logic [IDX_W-1:0]     irq_idx_o
);
    logic [NUM_LINES-1:0] lvl_mode_q, edge_pol_q, level_pol_q;
    logic [NUM_LINES-1:0] mask_q, status_q;
    logic [NUM_LINES-1:0] pin_now, pin_prev, trig_evt, wbits;

    assign wbits = bus_wdata_i[NUM_LINES-1:0];

    eic_sync #(.W(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .now_o  (pin_now),
        .prev_o (pin_prev)
    );

    eic_trigger #(.W(NUM_LINES)) u_trig (
        .now_i       (pin_now),
        .prev_i      (pin_prev),
        .lvl_mode_i  (lvl_mode_q),
        .edge_pol_i  (edge_pol_q),
        .level_pol_i (level_pol_q),
        .evt_o       (trig_evt)
    );

    // Configuration and mask registers, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_mode_q  <= '0;
            edge_pol_q  <= '0;
            level_pol_q <= '0;
            mask_q      <= '0;
        end else if (bus_we_i) begin
            case (bus_addr_i)
                A_TRIG_TYPE: lvl_mode_q  <= wbits;
                A_EDGE_POL:  edge_pol_q  <= wbits;
                A_LEVEL_POL: level_pol_q <= wbits;
                A_MASK_SET:  mask_q      <= mask_q | wbits;
                A_MASK_CLR:  mask_q      <= mask_q & ~wbits;
                default: ;
            endcase
        end
    end

    // Status register: clear by writing ones, triggers take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (bus_we_i && bus_addr_i == A_STATUS_CLR) begin
            status_q <= (status_q & ~wbits) | trig_evt;
        end else begin
            status_q <= status_q | trig_evt;
        end
    end

    // Combinational read mux, zero-extended above NUM_LINES.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_TRIG_TYPE: bus_rdata_o[NUM_LINES-1:0] = lvl_mode_q;
            A_EDGE_POL:  bus_rdata_o[NUM_LINES-1:0] = edge_pol_q;
            A_LEVEL_POL: bus_rdata_o[NUM_LINES-1:0] = level_pol_q;
            A_MASK:      bus_rdata_o[NUM_LINES-1:0] = mask_q;
            A_STATUS:    bus_rdata_o[NUM_LINES-1:0] = status_q;
            default:     bus_rdata_o = '0;
        endcase
    end

    eic_prio #(.W(NUM_LINES), .IDX_W(IDX_W)) u_prio (
        .pend_i (status_q & mask_q),
        .any_o  (irq_o),
        .idx_o  (irq_idx_o)
    );
endmodule

// File: rtl/eic_checker.sv
// Module: assertion checker bound to ext_irq_ctrl. Observes ports and
// the status/mask/event signals; drives nothing.
module eic_checker
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 irq,
    input logic [IDX_W-1:0]     irq_idx,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] evt
);
    logic [NUM_LINES-1:0] pend;
    assign pend = status_q & mask_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STATUS_CLR)
        |=> ((status_q & $past(bus_wdata[NUM_LINES-1:0] & ~evt)) == '0)); // R1

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK_SET)
        |=> ((mask_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0]))); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK_CLR)
        |=> ((mask_q & $past(bus_wdata[NUM_LINES-1:0])) == '0)); // R2

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q[irq_idx] && mask_q[irq_idx])); // R7

    AST_IDX_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend >> irq_idx) == NUM_LINES'(1))); // R8

    AST_TRIGGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt))); // R12

    if (NUM_LINES < DATA_W) begin : g_upper
        AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata[DATA_W-1:NUM_LINES] == '0)); // R6
    end
endmodule

bind ext_irq_ctrl eic_checker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr_i),
    .bus_we    (bus_we_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .irq       (irq_o),
    .irq_idx   (irq_idx_o),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .evt       (trig_evt)
);

// File: tb/ext_irq_ctrl_bench.sv
// Directed bench for ext_irq_ctrl: one task per scenario.
module ext_irq_ctrl_bench;
    localparam int N = 8;
    localparam int IW = 3;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pins = '1;
    logic [3:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    logic [IW-1:0] idx;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    ext_irq_ctrl #(.NUM_LINES(N)) u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(pins), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .irq_idx_o(idx)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Change one pin at a negedge and wait until status can show it.
    task automatic drive_pin(input int line, input logic v);
        @(negedge clk);
        pins[line] = v;
        settle(3);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R9 reset reg", d, 32'h0);
        end
        chk("R9 reset irq", {31'h0, irq}, 32'h0);
        chk("R9 reset idx", {29'h0, idx}, 32'h0);
    endtask

    task automatic t_default_falling;
        logic [31:0] d;
        @(negedge clk);
        pins[0] = 1'b0;
        settle(2);
        rd(4'd6, d);
        chk("R10 not yet after 2 edges", d, 32'h0);
        settle(1);
        rd(4'd6, d);
        chk("R9 R10 falling sets after 3 edges", d, 32'h1);
        drive_pin(0, 1'b1);
        wr(4'd7, 32'h0);
        rd(4'd6, d);
        chk("R1 clear with zero no effect", d, 32'h1);
        wr(4'd7, 32'h1);
        rd(4'd6, d);
        chk("R1 clear with one", d, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(4'd3, 32'h0A);
        rd(4'd5, d);
        chk("R2 mask set", d, 32'h0A);
        wr(4'd4, 32'h02);
        rd(4'd5, d);
        chk("R2 mask clear", d, 32'h08);
    endtask

    task automatic t_rising;
        logic [31:0] d;
        wr(4'd1, 32'h02);
        drive_pin(1, 1'b0);
        rd(4'd6, d);
        chk("R4 falling ignored in rising mode", d, 32'h0);
        drive_pin(1, 1'b1);
        rd(4'd6, d);
        chk("R4 rising sets", d, 32'h02);
        wr(4'd7, 32'h02);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(4'd2, 32'h08);
        wr(4'd0, 32'h08);
        settle(2);
        rd(4'd6, d);
        chk("R3 R5 high level sets", d & 32'h08, 32'h08);
        wr(4'd7, 32'h08);
        rd(4'd6, d);
        chk("R11 clear while active does not stick", d & 32'h08, 32'h08);
        wr(4'd2, 32'h0);
        settle(1);
        wr(4'd7, 32'h08);
        rd(4'd6, d);
        chk("R5 inactive under active-low, clear sticks", d, 32'h0);
        drive_pin(3, 1'b0);
        rd(4'd6, d);
        chk("R5 low level sets", d, 32'h08);
        drive_pin(3, 1'b1);
        wr(4'd7, 32'h08);
        wr(4'd0, 32'h0);
        rd(4'd6, d);
        chk("R3 back to edge, status clear", d, 32'h0);
    endtask

    task automatic t_masked_edge;
        logic [31:0] d;
        drive_pin(6, 1'b0);
        rd(4'd6, d);
        chk("R12 masked line still sets status", d, 32'h40);
        chk("R7 masked line no irq", {31'h0, irq}, 32'h0);
        wr(4'd3, 32'h40);
        chk("R7 irq after unmask", {31'h0, irq}, 32'h1);
        chk("R8 idx of only line", {29'h0, idx}, 32'd6);
        wr(4'd7, 32'h40);
        chk("R7 irq drops after clear", {31'h0, irq}, 32'h0);
        drive_pin(6, 1'b1);
    endtask

    task automatic t_priority;
        wr(4'd3, 32'h24);
        @(negedge clk);
        pins[2] = 1'b0; pins[5] = 1'b0;
        settle(3);
        chk("R7 irq with two pending", {31'h0, irq}, 32'h1);
        chk("R8 highest is 5", {29'h0, idx}, 32'd5);
        wr(4'd7, 32'h20);
        chk("R8 next highest is 2", {29'h0, idx}, 32'd2);
        wr(4'd7, 32'h04);
        chk("R7 none pending", {31'h0, irq}, 32'h0);
        @(negedge clk);
        pins[2] = 1'b1; pins[5] = 1'b1;
        settle(3);
    endtask

    task automatic t_edge_wins;
        logic [31:0] d;
        @(negedge clk);
        pins[4] = 1'b0;
        settle(2);
        addr = 4'd7; wdata = 32'h10; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        rd(4'd6, d);
        chk("R12 edge beats same-cycle clear", d, 32'h10);
        wr(4'd7, 32'h10);
        rd(4'd6, d);
        chk("R1 later clear removes it", d, 32'h0);
        drive_pin(4, 1'b1);
    endtask

    task automatic t_impl;
        logic [31:0] d;
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d);
        chk("R6 trig_type shows implemented lines", d, 32'h0000_00FF);
        wr(4'd0, 32'h0);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd5, d);
        chk("R6 mask upper bits zero", d, 32'h0000_00FF);
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(4);
        t_reset();
        t_default_falling();
        t_mask();
        t_rising();
        t_level();
        t_masked_edge();
        t_priority();
        t_edge_wins();
        t_impl();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule